// File: doc/BRIEF.md
# Symmetric Multilevel PWM Phase Sequencer

This block is the final timing stage of a multilevel space-vector modulator that works through an equivalent two-level reference. Each switching cycle it receives the three components of the two-level reference, measured from the centre of the small hexagon that holds the full reference, together with the integer starting level of every phase and half the switching period in clock ticks. From these it computes, per phase, the carrier count at which that phase steps up by one level. It uses a max/min offset formula that needs no sector decision. It then drives the three integer phase levels from a triangular up/down carrier.

Each phase rests at its starting level, steps up one level once the carrier reaches that phase's instant, and steps back down at the same count on the falling slope. The result is a seven-segment pattern that is mirror-symmetric about mid-period. A cycle that starts on (1 0 -2) with instants in a-b-c order passes through (2 0 -2), (2 1 -2), (2 1 -1) at the peak and returns the same way. Every input is captured only when the carrier returns to zero.

A small three-state controller runs the carrier. ST_IDLE is held in reset. The transition IDLE to RISE performs the first capture. RISE counts up and moves to FALL when the count is about to reach the half period. FALL counts down and moves back to RISE when the count leaves 1, and that transition captures the inputs for the next cycle.

Top module: `mlpwm_level_sequencer`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, all three level outputs are 0. The first edge after release captures the inputs and places the carrier at count 0.
- R2: With H the captured half period (values below 2 are treated as 2), the carrier visits 0, 1, ..., H and then H-1, ..., 1, so one cycle lasts 2H clocks.
- R3: References are signed two's complement per-unit values with FRAC fraction bits (default 12, so 1.0 = 4096). With mx and mn the largest and smallest of the three, the step instant of phase j is T_j = floor(H*k_j / 2^(FRAC+1)), where k_j = 2^FRAC + mx + mn - 2*ref_j, clamped to [0, 2^(FRAC+1)]. This equals (1/4 + Vavg - ref_j/2)*Ts with Vavg = (mx+mn)/4 and Ts = 2H.
- R4: During a cycle, phase j outputs its starting level + 1 whenever the carrier count is at or above its effective instant E_j and E_j < H. Otherwise it outputs its starting level. This makes the pattern symmetric about the peak.
- R5: An instant of 0 keeps the phase one level up for the whole cycle. An instant of H or more never raises the phase.
- R6: Equal instants are ordered a, then b, then c. Taking phases in ascending instant with that tie order, each effective instant is the larger of its own instant and the previous effective instant + 1.
- R7: Between two clock edges inside one cycle (every edge except a capture edge), at most one phase level changes.
- R8: Reference, starting-level and half-period inputs that change in mid-cycle have no effect until the next capture edge.
- R9: References (+0.25, 0, -0.25) with starting levels (1, 0, -2) and H = 20 give instants 5, 10, 15. The cycle then runs (1 0 -2) → (2 0 -2) → (2 1 -2) → (2 1 -1) and back in reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | REF_W | Two-level equivalent reference, phase a, signed per-unit |
| ref_b | input | REF_W | Two-level equivalent reference, phase b, signed per-unit |
| ref_c | input | REF_W | Two-level equivalent reference, phase c, signed per-unit |
| sdown_a | input | LVL_W | Starting level of phase a, signed |
| sdown_b | input | LVL_W | Starting level of phase b, signed |
| sdown_c | input | LVL_W | Starting level of phase c, signed |
| half_period | input | CNT_W | Half switching period in clocks (minimum 2) |
| level_a | output | LVL_W | Integer output level of phase a, signed |
| level_b | output | LVL_W | Integer output level of phase b, signed |
| level_c | output | LVL_W | Integer output level of phase c, signed |

## Verification
Two functions of the block can fall on the same clock edge. One is the per-phase step decision taken at a carrier count. The other is either a further phase's step at the same count, or the capture of new inputs at the cycle boundary. Vectors with two or three equal instants, instants clamped to 0 and to H, and an instant spread past the peak provoke the first collision. Inputs rewritten in the middle of every cycle, including a change of half period, provoke the second. The bench judges every sample against levels derived from R3 to R6, and counts the phases that moved between adjacent samples.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
    localparam int NPH = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } carrier_state_e;
endpackage

// File: rtl/mlpwm_instant_calc.sv
module mlpwm_instant_calc
    import mlpwm_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int FRAC  = 12,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_v   [NPH],
    input  logic        [CNT_W-1:0] half_q,
    output logic        [CNT_W-1:0] inst    [NPH]
);
    localparam int SW     = REF_W + 3;
    localparam int KW     = FRAC + 2;
    localparam int PW     = CNT_W + KW;
    localparam int ONE_I  = 1 << FRAC;
    localparam int FULL_I = 1 << (FRAC + 1);

    logic signed [SW-1:0] ref_mx;
    logic signed [SW-1:0] ref_mn;
    logic signed [SW-1:0] mm_sum;

    // Largest and smallest reference component, sign-extended
    always_comb begin
        ref_mx = SW'(ref_v[0]);
        ref_mn = SW'(ref_v[0]);
        for (int j = 1; j < NPH; j++) begin
            if (SW'(ref_v[j]) > ref_mx) ref_mx = SW'(ref_v[j]);
            if (SW'(ref_v[j]) < ref_mn) ref_mn = SW'(ref_v[j]);
        end
        mm_sum = ref_mx + ref_mn;
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        logic signed [SW-1:0] k_raw;
        logic        [KW-1:0] k_cl;
        logic        [PW-1:0] prod;

        always_comb begin
            k_raw = SW'(ONE_I) + mm_sum - (SW'(ref_v[g]) <<< 1);
            if (k_raw < 0)
                k_cl = '0;
            else if (k_raw > SW'(FULL_I))
                k_cl = KW'(FULL_I);
            else
                k_cl = KW'(k_raw);
            prod = PW'(half_q) * PW'(k_cl);
        end

        assign inst[g] = CNT_W'(prod >> (FRAC + 1));

        // R5: a clamped instant never lies beyond the carrier peak
        a_r5_inst_bound: assert property (@(posedge clk) disable iff (!rst_n)
            inst[g] <= half_q);
    end
endmodule

// File: rtl/mlpwm_edge_spread.sv
module mlpwm_edge_spread
    import mlpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] inst  [NPH],
    output logic [CNT_W+1:0] e_out [NPH]
);
    localparam int EW = CNT_W + 2;

    logic [1:0]    rank   [NPH];
    logic [EW-1:0] srt    [NPH];
    logic [EW-1:0] e_srt  [NPH];

    // Position of phase j in ascending instant order, ties broken a, b, c
    function automatic logic [1:0] rank_of(input int j, input logic [CNT_W-1:0] v [NPH]);
        logic [1:0] r;
        r = '0;
        for (int k = 0; k < NPH; k++) begin
            if (k < j && v[k] <= v[j]) r = r + 2'd1;
            if (k > j && v[k] <  v[j]) r = r + 2'd1;
        end
        return r;
    endfunction

    for (genvar g = 0; g < NPH; g++) begin : g_rank
        assign rank[g] = rank_of(g, inst);
    end

    always_comb begin
        for (int r = 0; r < NPH; r++) srt[r] = '0;
        for (int j = 0; j < NPH; j++) srt[rank[j]] = EW'(inst[j]);
        e_srt[0] = srt[0];
        for (int r = 1; r < NPH; r++)
            e_srt[r] = (srt[r] > e_srt[r-1]) ? srt[r] : e_srt[r-1] + EW'(1);
        for (int j = 0; j < NPH; j++) e_out[j] = e_srt[rank[j]];
    end

    // R6: effective instants never coincide
    a_r6_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (e_out[0] != e_out[1]) && (e_out[0] != e_out[2]) && (e_out[1] != e_out[2]));
    // R6: tie order a before b before c
    a_r6_tie_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (inst[0] == inst[1]) |-> (e_out[0] < e_out[1]));
    a_r6_tie_bc: assert property (@(posedge clk) disable iff (!rst_n)
        (inst[1] == inst[2]) |-> (e_out[1] < e_out[2]));
endmodule

// File: rtl/mlpwm_carrier_fsm.sv
module mlpwm_carrier_fsm
    import mlpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] half_q,
    output logic             load,
    output logic             active
);
    localparam logic [CNT_W-1:0] HALF_MIN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    carrier_state_e   state, state_nx;
    logic [CNT_W-1:0] count_nx;
    logic [CNT_W-1:0] half_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            count  <= '0;
            half_q <= HALF_MIN;
        end else begin
            state  <= state_nx;
            count  <= count_nx;
            half_q <= half_nx;
        end
    end

    // Next state and carrier
    always_comb begin
        state_nx = state;
        count_nx = count;
        unique case (state)
            ST_IDLE: begin
                state_nx = ST_RISE;
                count_nx = '0;
            end
            ST_RISE: begin
                if (count == half_q - ONE) state_nx = ST_FALL;
                count_nx = count + ONE;
            end
            ST_FALL: begin
                if (count == ONE) begin
                    state_nx = ST_RISE;
                    count_nx = '0;
                end else begin
                    count_nx = count - ONE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                count_nx = '0;
            end
        endcase
        half_nx = load ? ((half_in < HALF_MIN) ? HALF_MIN : half_in) : half_q;
    end

    // Outputs
    always_comb begin
        load   = (state == ST_IDLE) || ((state == ST_FALL) && (count == ONE));
        active = (state != ST_IDLE);
    end

    // R2: carrier never passes the captured half period
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= half_q);
    // R2: the up slope turns into the down slope exactly at the peak
    a_r2_peak_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE && count == half_q - ONE) |=> (state == ST_FALL && count == $past(half_q)));
    // R8: half period only moves on a capture edge
    a_r8_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(half_q));
endmodule

// File: rtl/mlpwm_level_sequencer.sv
module mlpwm_level_sequencer
    import mlpwm_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int FRAC  = 12,
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic signed [LVL_W-1:0] sdown_a,
    input  logic signed [LVL_W-1:0] sdown_b,
    input  logic signed [LVL_W-1:0] sdown_c,
    input  logic        [CNT_W-1:0] half_period,
    output logic signed [LVL_W-1:0] level_a,
    output logic signed [LVL_W-1:0] level_b,
    output logic signed [LVL_W-1:0] level_c
);
    localparam int EW = CNT_W + 2;

    logic signed [REF_W-1:0] ref_in [NPH];
    logic signed [LVL_W-1:0] sd_in  [NPH];
    logic signed [REF_W-1:0] ref_q  [NPH];
    logic signed [LVL_W-1:0] sd_q   [NPH];
    logic signed [LVL_W-1:0] lvl    [NPH];
    logic        [CNT_W-1:0] inst   [NPH];
    logic        [EW-1:0]    e_eff  [NPH];

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] half_q;
    logic             load;
    logic             active;

    assign ref_in[0] = ref_a;
    assign ref_in[1] = ref_b;
    assign ref_in[2] = ref_c;
    assign sd_in[0]  = sdown_a;
    assign sd_in[1]  = sdown_b;
    assign sd_in[2]  = sdown_c;

    mlpwm_carrier_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_in (half_period),
        .count   (count),
        .half_q  (half_q),
        .load    (load),
        .active  (active)
    );

    mlpwm_instant_calc #(.REF_W(REF_W), .FRAC(FRAC), .CNT_W(CNT_W)) u_calc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_v  (ref_q),
        .half_q (half_q),
        .inst   (inst)
    );

    mlpwm_edge_spread #(.CNT_W(CNT_W)) u_spread (
        .clk   (clk),
        .rst_n (rst_n),
        .inst  (inst),
        .e_out (e_eff)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_lane
        logic step_up;

        // Cycle-boundary capture of reference and starting level
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_q[g] <= '0;
                sd_q[g]  <= '0;
            end else if (load) begin
                ref_q[g] <= ref_in[g];
                sd_q[g]  <= sd_in[g];
            end
        end

        assign step_up = active && (e_eff[g] < EW'(half_q)) && (EW'(count) >= e_eff[g]);
        assign lvl[g]  = sd_q[g] + LVL_W'(step_up);

        // R8: captured values hold between boundaries
        a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> ($stable(ref_q[g]) && $stable(sd_q[g])));
    end

    assign level_a = lvl[0];
    assign level_b = lvl[1];
    assign level_c = lvl[2];

    // R7: within a cycle only one phase moves per edge
    a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($countones({level_a != $past(level_a),
                               level_b != $past(level_b),
                               level_c != $past(level_c)}) <= 1));
endmodule

// File: tb/mlpwm_level_sequencer_tb.sv
module mlpwm_level_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // ref_a, ref_b, ref_c, sd_a, sd_b, sd_c, half, E_a, E_b, E_c
    localparam int VEC [NV][10] = '{
        '{ 1024,     0, -1024,  1,  0, -2, 20,  5, 10, 15},
        '{    0,     0,     0,  0,  0,  0, 20, 10, 11, 12},
        '{ 4096, -4096,     0, -2,  1,  0, 20,  0, 20, 10},
        '{-2048, -2048,  4096,  0, -1, -2, 20, 20, 21,  0},
        '{ 2048,  2048, -4096, -1, -1,  1, 20,  0,  1, 20},
        '{ 1000,  -300,  -700,  0,  1, -1, 20,  5, 12, 14},
        '{-1024, -1024,  2048,  1,  1,  1, 20, 17, 18,  2},
        '{ 1024,     0, -1024,  1,  0, -2,  8,  2,  4,  6}
    };
    localparam string TAG [NV] = '{"R9", "R6", "R5", "R6", "R5", "R3", "R6", "R2"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [15:0] ref_a, ref_b, ref_c;
    logic signed [3:0]  sdown_a, sdown_b, sdown_c;
    logic        [15:0] half_period;
    logic signed [3:0]  level_a, level_b, level_c;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlpwm_level_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_a       (ref_a),
        .ref_b       (ref_b),
        .ref_c       (ref_c),
        .sdown_a     (sdown_a),
        .sdown_b     (sdown_b),
        .sdown_c     (sdown_c),
        .half_period (half_period),
        .level_a     (level_a),
        .level_b     (level_b),
        .level_c     (level_c)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_vec(input int v);
        ref_a       = 16'(VEC[v][0]);
        ref_b       = 16'(VEC[v][1]);
        ref_c       = 16'(VEC[v][2]);
        sdown_a     = 4'(VEC[v][3]);
        sdown_b     = 4'(VEC[v][4]);
        sdown_c     = 4'(VEC[v][5]);
        half_period = 16'(VEC[v][6]);
    endtask

    function automatic int exp_lvl(input int sd, input int e, input int c, input int h);
        return sd + (((c >= e) && (e < h)) ? 1 : 0);
    endfunction

    // One full carrier cycle of vector v; the next vector is applied mid-cycle
    task automatic run_cycle(input int v, input int nxt);
        int h = VEC[v][6];
        int pa = 0, pb = 0, pc = 0;
        for (int i = 0; i < 2*h; i++) begin
            int c = (i <= h) ? i : 2*h - i;
            string t = (i > 3) ? {"R4 R8 ", TAG[v]} : {"R4 ", TAG[v]};
            @(negedge clk);
            chk({t, " phase a"}, int'(level_a), exp_lvl(VEC[v][3], VEC[v][7], c, h));
            chk({t, " phase b"}, int'(level_b), exp_lvl(VEC[v][4], VEC[v][8], c, h));
            chk({t, " phase c"}, int'(level_c), exp_lvl(VEC[v][5], VEC[v][9], c, h));
            if (i > 0)
                chk("R7 single phase change",
                    int'(int'(level_a) != pa) + int'(int'(level_b) != pb) + int'(int'(level_c) != pc) <= 1 ? 1 : 0, 1);
            pa = int'(level_a);
            pb = int'(level_b);
            pc = int'(level_c);
            if (i == 3) apply_vec(nxt);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        apply_vec(0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset level a", int'(level_a), 0);
        chk("R1 reset level b", int'(level_b), 0);
        chk("R1 reset level c", int'(level_c), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 before first edge a", int'(level_a), 0);

        for (int v = 0; v < NV; v++)
            run_cycle(v, (v + 1 < NV) ? v + 1 : 0);

        // R1: reset in mid-run returns all levels to 0, then restart on vector 0
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset a", int'(level_a), 0);
        chk("R1 mid-run reset b", int'(level_b), 0);
        chk("R1 mid-run reset c", int'(level_c), 0);
        rst_n = 1'b1;
        run_cycle(0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule